// File: doc/BRIEF.md
# Aligned I/O Window Decoder

This block maps a 16-bit host I/O address onto a set of peripheral devices. Each device has a programmable base register and an enable flag. Each device also owns a naturally aligned window of 2, 4, 8 or 16 bytes. When a host access falls inside an enabled window, the decoder raises that device's select line one clock later. At the same time it reports the register offset inside the window.

The base registers keep every programmed value legal. On write, the bits that lie inside the window are cleared. The bits above each device's address ceiling are cleared as well. The same masked value is what a read-back returns.

The default configuration has six devices, each with its own range class:
- Device 0 is a 2-byte clock window.
- Devices 1 to 3 are 8-byte communication windows.
- These four low-space devices cannot reach 800h or above.
- Device 4 is an 8-byte printer window. It is capped at 3F8h and also answers on the alias that differs in address bit 10.
- Device 5 is a 16-byte window that can sit anywhere in the 16-bit space.

Top module: `io_window_decoder`

## Requirements
- R1: After reset, every base register reads 0000h, every enable reads 0, and no select is asserted.
- R2: A write stores the data with the window's offset bits cleared. Device 0 clears bit 0, devices 1 to 4 clear bits [2:0], and device 5 clears bits [3:0]. Read-back returns the stored value.
- R3: Devices 0 to 3 always read back with bits [15:11] equal to zero.
- R4: Device 4 always reads back with bits [15:10] equal to zero, so its largest base is 03F8h.
- R5: Device 5 keeps every bit above its offset bits, so bases up to FFF0h are reachable.
- R6: An access with host_valid high selects an enabled device when all address bits above its offset bits equal its base. The select appears on dev_sel bit i in the cycle after the access.
- R7: dev_off[3:0] carries the address bits below the window boundary, with all higher bits zero.
- R8: For device 4, address bit 10 is excluded from the comparison and is reported on dev_off[4]. For every other device, dev_off[4] is 0.
- R9: A device whose enable is 0 is never selected.
- R10: When several enabled windows match, only the lowest-numbered device is selected. At most one select bit is ever high.
- R11: The cycle after host_valid is low, dev_sel is all zero.
- R12: A configuration write with an index of NDEV or above changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Device index for the write |
| cfg_base | input | 16 | Base value to write, before masking |
| cfg_en | input | 1 | Enable value to write |
| rd_idx | input | IDX_W | Device index for read-back |
| rd_base | output | 16 | Stored base of device rd_idx |
| rd_en | output | 1 | Stored enable of device rd_idx |
| host_valid | input | 1 | Host address is valid this cycle |
| host_addr | input | 16 | Host I/O address |
| dev_sel | output | NDEV | One-hot device select, registered |
| dev_off | output | 5 | Register offset inside the selected window, registered |

## Verification
All-ones writes to every device show that each device's alignment mask and ceiling mask are distinct and correctly placed.

The decode path is driven with two kinds of address:
- Addresses formed from a programmed base plus random low bits, which separate a correct offset width from a wrong one.
- Addresses with a single upper bit flipped, which show whether that bit is compared or ignored. For the printer window, flipping bit 10 must still hit and must appear on the offset.

Overlapping enabled windows check the priority order, and disabled or idle cases check that selects stay quiet. Fully random addresses cover the miss path.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

    localparam int ADDR_W = 16;
    localparam int OFF_W  = 5;

    typedef enum logic [1:0] {
        CLS_LOW,
        CLS_PRINTER,
        CLS_OPEN
    } range_class_e;

    function automatic int win_log(int dev);
        case (dev)
            0:       return 1;
            1, 2, 3: return 3;
            4:       return 3;
            default: return 4;
        endcase
    endfunction

    function automatic range_class_e dev_class(int dev);
        if (dev < 4)  return CLS_LOW;
        if (dev == 4) return CLS_PRINTER;
        return CLS_OPEN;
    endfunction

    function automatic logic [ADDR_W-1:0] low_mask(int dev);
        return ADDR_W'((1 << win_log(dev)) - 1);
    endfunction

    // Bits a base register may hold.
    function automatic logic [ADDR_W-1:0] base_keep(int dev);
        logic [ADDR_W-1:0] k;
        k = ~low_mask(dev);
        case (dev_class(dev))
            CLS_LOW:     k = k & 16'h07FF;
            CLS_PRINTER: k = k & 16'h03FF;
            default:     k = k;
        endcase
        return k;
    endfunction

    // Address bits that take part in the window comparison.
    function automatic logic [ADDR_W-1:0] cmp_keep(int dev);
        logic [ADDR_W-1:0] k;
        k = ~low_mask(dev);
        if (dev_class(dev) == CLS_PRINTER) k[10] = 1'b0;
        return k;
    endfunction

endpackage

// File: rtl/io_base_mask.sv
module io_base_mask #(
    parameter int NDEV  = 6,
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0]                 idx,
    input  logic [io_dec_pkg::ADDR_W-1:0]    data,
    output logic                             idx_ok,
    output logic [io_dec_pkg::ADDR_W-1:0]    masked
);
    import io_dec_pkg::*;

    localparam int NTAB = 1 << IDX_W;

    logic [NTAB-1:0][ADDR_W-1:0] keep;

    for (genvar g = 0; g < NTAB; g++) begin : g_keep
        if (g < NDEV) begin : g_real
            assign keep[g] = base_keep(g);
        end else begin : g_none
            assign keep[g] = '0;
        end
    end

    assign idx_ok = (int'(idx) < NDEV);
    assign masked = data & keep[idx];
endmodule

// File: rtl/io_win_match.sv
module io_win_match #(
    parameter int DEV = 0
) (
    input  logic                             valid,
    input  logic                             en,
    input  logic [io_dec_pkg::ADDR_W-1:0]    base,
    input  logic [io_dec_pkg::ADDR_W-1:0]    addr,
    output logic                             hit,
    output logic [io_dec_pkg::OFF_W-1:0]     off
);
    import io_dec_pkg::*;

    localparam logic [ADDR_W-1:0] CMP  = cmp_keep(DEV);
    localparam logic [ADDR_W-1:0] LOWM = low_mask(DEV);
    localparam bit                ALIAS = (dev_class(DEV) == CLS_PRINTER);

    assign hit = valid && en && (((addr ^ base) & CMP) == '0);
    assign off = {ALIAS ? addr[10] : 1'b0, addr[3:0] & LOWM[3:0]};
endmodule

// File: rtl/io_prio_pick.sv
module io_prio_pick #(
    parameter int NDEV = 6
) (
    input  logic [NDEV-1:0]                           hits,
    input  logic [NDEV-1:0][io_dec_pkg::OFF_W-1:0]    offs,
    output logic [NDEV-1:0]                           sel,
    output logic [io_dec_pkg::OFF_W-1:0]              off
);
    always_comb begin
        logic found;
        found = 1'b0;
        sel   = '0;
        off   = '0;
        for (int i = 0; i < NDEV; i++) begin
            if (hits[i] && !found) begin
                found  = 1'b1;
                sel[i] = 1'b1;
                off    = offs[i];
            end
        end
    end
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder #(
    parameter int NDEV  = 6,
    parameter int IDX_W = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [15:0]      cfg_base,
    input  logic             cfg_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [15:0]      rd_base,
    output logic             rd_en,
    input  logic             host_valid,
    input  logic [15:0]      host_addr,
    output logic [NDEV-1:0]  dev_sel,
    output logic [4:0]       dev_off
);
    import io_dec_pkg::*;

    typedef struct packed {
        logic [NDEV-1:0][ADDR_W-1:0] base;
        logic [NDEV-1:0]             en;
        logic [NDEV-1:0]             sel;
        logic [OFF_W-1:0]            off;
    } state_t;

    state_t st_d, st_q;

    logic                        wr_ok;
    logic [ADDR_W-1:0]           wr_masked;
    logic [NDEV-1:0]             win_hit;
    logic [NDEV-1:0][OFF_W-1:0]  win_off;
    logic [NDEV-1:0]             pick_sel;
    logic [OFF_W-1:0]            pick_off;
    logic [NDEV-1:0]             en_now;

    io_base_mask #(.NDEV(NDEV), .IDX_W(IDX_W)) u_mask (
        .idx    (cfg_idx),
        .data   (cfg_base),
        .idx_ok (wr_ok),
        .masked (wr_masked)
    );

    for (genvar g = 0; g < NDEV; g++) begin : g_win
        io_win_match #(.DEV(g)) u_match (
            .valid (host_valid),
            .en    (st_q.en[g]),
            .base  (st_q.base[g]),
            .addr  (host_addr),
            .hit   (win_hit[g]),
            .off   (win_off[g])
        );
    end

    io_prio_pick #(.NDEV(NDEV)) u_pick (
        .hits (win_hit),
        .offs (win_off),
        .sel  (pick_sel),
        .off  (pick_off)
    );

    always_comb begin
        st_d     = st_q;
        st_d.sel = pick_sel;
        st_d.off = pick_off;
        for (int i = 0; i < NDEV; i++) begin
            if (cfg_we && wr_ok && (int'(cfg_idx) == i)) begin
                st_d.base[i] = wr_masked;
                st_d.en[i]   = cfg_en;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_base = '0;
        rd_en   = 1'b0;
        for (int i = 0; i < NDEV; i++) begin
            if (int'(rd_idx) == i) begin
                rd_base = st_q.base[i];
                rd_en   = st_q.en[i];
            end
        end
    end

    assign en_now  = st_q.en;
    assign dev_sel = st_q.sel;
    assign dev_off = st_q.off;
endmodule

// File: rtl/io_window_decoder_chk.sv
module io_window_decoder_chk #(
    parameter int NDEV  = 6,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_valid,
    input logic [IDX_W-1:0] rd_idx,
    input logic [15:0]      rd_base,
    input logic [NDEV-1:0]  dev_sel,
    input logic [NDEV-1:0]  en_now
);
    import io_dec_pkg::*;

    assert_one_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_sel));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !host_valid |=> (dev_sel == '0));

    for (genvar g = 0; g < NDEV; g++) begin : g_dev
        localparam logic [15:0] LM = low_mask(g);

        assert_disabled_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
            dev_sel[g] |-> $past(en_now[g]));

        assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(rd_idx) == g) |-> ((rd_base & LM) == '0));

        if (dev_class(g) == CLS_LOW) begin : g_low
            assert_low_space_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(rd_idx) == g) |-> (rd_base[15:11] == '0));
        end
        if (dev_class(g) == CLS_PRINTER) begin : g_prn
            assert_printer_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(rd_idx) == g) |-> (rd_base <= 16'h03F8));
        end
    end
endmodule

bind io_window_decoder io_window_decoder_chk #(.NDEV(NDEV), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_valid (host_valid),
    .rd_idx     (rd_idx),
    .rd_base    (rd_base),
    .dev_sel    (dev_sel),
    .en_now     (en_now)
);

// File: tb/io_window_decoder_test.sv
`timescale 1ns/1ps
module io_window_decoder_test;
    localparam int N = 6;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [15:0]   cfg_base = '0;
    logic          cfg_en = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic [15:0]   rd_base;
    logic          rd_en;
    logic          host_valid = 1'b0;
    logic [15:0]   host_addr = '0;
    logic [N-1:0]  dev_sel;
    logic [4:0]    dev_off;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [15:0] m_base [N];
    logic        m_en   [N];

    always #2.5 clk = ~clk;

    io_window_decoder #(.NDEV(N)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_en(cfg_en), .rd_idx(rd_idx),
        .rd_base(rd_base), .rd_en(rd_en), .host_valid(host_valid),
        .host_addr(host_addr), .dev_sel(dev_sel), .dev_off(dev_off)
    );

    function automatic int wlog(int i);
        if (i == 0) return 1;
        if (i <= 4) return 3;
        return 4;
    endfunction

    function automatic logic [15:0] keep_ref(int i);
        logic [15:0] k;
        k = 16'hFFFF << wlog(i);
        if (i < 4)       k = k & 16'h07FF;
        else if (i == 4) k = k & 16'h03FF;
        return k;
    endfunction

    task automatic exp_decode(input logic v, input logic [15:0] a,
                              output logic [N-1:0] s, output logic [4:0] o);
        logic [15:0] cm;
        s = '0;
        o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            cm = 16'hFFFF << wlog(i);
            if (i == 4) cm[10] = 1'b0;
            if (v && m_en[i] && ((a & cm) == (m_base[i] & cm))) begin
                s = N'(1) << i;
                o = {(i == 4) ? a[10] : 1'b0, a[3:0] & 4'((1 << wlog(i)) - 1)};
            end
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input int idx, input logic [15:0] wd,
                        input logic en, input logic v, input logic [15:0] a,
                        input string req);
        logic [N-1:0] es;
        logic [4:0]   eo;
        @(negedge clk);
        cfg_we = we; cfg_idx = IW'(idx); cfg_base = wd; cfg_en = en;
        host_valid = v; host_addr = a;
        exp_decode(v, a, es, eo);
        @(posedge clk);
        #1;
        chk({req, " sel"}, 32'(dev_sel), 32'(es));
        chk({req, " off"}, 32'(dev_off), 32'(eo));
        if (we && idx < N) begin
            m_base[idx] = wd & keep_ref(idx);
            m_en[idx]   = en;
        end
        cfg_we = 1'b0;
        host_valid = 1'b0;
    endtask

    task automatic cfg(input int idx, input logic [15:0] wd, input logic en);
        step(1'b1, idx, wd, en, 1'b0, 16'h0, "R11");
    endtask

    task automatic look(input logic [15:0] a, input string req);
        step(1'b0, 0, 16'h0, 1'b0, 1'b1, a, req);
    endtask

    task automatic rb(input int idx, input string req);
        @(negedge clk);
        rd_idx = IW'(idx);
        #1;
        chk({req, " base"}, 32'(rd_base), 32'(m_base[idx]));
        chk({req, " en"}, 32'(rd_en), 32'(m_en[idx]));
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            m_base[i] = '0;
            m_en[i]   = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 sel", 32'(dev_sel), 32'h0);
        for (int i = 0; i < N; i++) rb(i, "R1");

        // R2 R3 R4 R5 all-ones writes
        for (int i = 0; i < N; i++) cfg(i, 16'hFFFF, 1'b0);
        rb(0, "R2 R3"); chk("R3 dev0 value", 32'(rd_base), 32'h07FE);
        rb(1, "R2 R3"); chk("R3 dev1 value", 32'(rd_base), 32'h07F8);
        rb(3, "R3");
        rb(4, "R4");    chk("R4 dev4 value", 32'(rd_base), 32'h03F8);
        rb(5, "R5");    chk("R5 dev5 value", 32'(rd_base), 32'hFFF0);

        // R12 out-of-range write ignored
        cfg(6, 16'h1230, 1'b1);
        cfg(7, 16'h4560, 1'b1);
        for (int i = 0; i < N; i++) rb(i, "R12");

        // R6 R7 R8 printer window and alias
        cfg(4, 16'h0378, 1'b1);
        look(16'h037A, "R6 R7");
        chk("R7 dev4 off", 32'(dev_off), 32'h02);
        look(16'h077A, "R8");
        chk("R8 alias off", 32'(dev_off), 32'h12);
        chk("R8 alias sel", 32'(dev_sel), 32'h10);
        look(16'h0B7A, "R8 miss");

        // R5 R7 top of space
        cfg(5, 16'hFFF3, 1'b1);
        look(16'hFFFF, "R5 R7");
        chk("R7 dev5 off", 32'(dev_off), 32'h0F);

        // R9 disabled device
        cfg(0, 16'h0070, 1'b0);
        look(16'h0070, "R9");
        chk("R9 quiet", 32'(dev_sel), 32'h0);

        // R10 overlap priority
        cfg(1, 16'h03F8, 1'b1);
        cfg(2, 16'h03F8, 1'b1);
        look(16'h03FD, "R10");
        chk("R10 winner", 32'(dev_sel), 32'h02);

        // R11 valid low
        step(1'b0, 0, 16'h0, 1'b0, 1'b0, 16'h03FD, "R11");

        // random mix R2 R6 R7 R8 R9 R10 R11
        for (int k = 0; k < 1500; k++) begin
            int r;
            int d;
            logic [15:0] a;
            r = int'($urandom_range(0, 9));
            d = int'($urandom_range(0, N - 1));
            if (r < 2) begin
                cfg(int'($urandom_range(0, 7)), 16'($urandom), 1'($urandom));
            end else if (r < 7) begin
                a = m_base[d] | 16'($urandom_range(0, 15));
                if (r == 5) a[10] = ~a[10];
                if (r == 6) a = a ^ (16'h1 << $urandom_range(0, 15));
                step(1'b0, 0, 16'h0, 1'b0, 1'($urandom_range(0, 7) != 0), a,
                     "R6 R7 R8 R9 R10 R11");
            end else if (r < 9) begin
                look(16'($urandom), "R6 R9");
            end else begin
                rb(d, "R2");
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule